// File: doc/BRIEF.md
# Dual 40-bit Saturating Accumulator Unit

This block keeps two 40-bit signed accumulators side by side and applies one arithmetic operation per clock to whichever one a select bit names. That accumulator is both the first operand and the destination, and the other one is left alone. The incoming operand comes from one of two places. It is either a 40-bit multiplier product, already sign-extended from 33 bits, or a 16-bit word that is aligned as a 1.15 fraction into the 1.31 field of the accumulator. For add and load, the operand can then pass through a signed barrel shift before it reaches the adder/subtracter.

The adder works on a widened copy of both operands, so the exact result is always known. From that exact result the block detects overflow out of bit 39. When saturation is enabled, an overflowing result is clamped to the largest positive or largest negative 40-bit value, whichever matches the true sign. A second flag marks a stored value that has spilled past the 1.31 field into the guard bits. Both accumulators and their two flags per accumulator are visible on read ports at all times.

Top module: `accu_dual40`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), both accumulators and all four flags read zero.
- R2: An add (`opCode` = 0) with `opValid` high writes the selected accumulator (`accSel` 0 = A, 1 = B) with its old value plus the shifted operand at the next rising clock edge.
- R3: A subtract (`opCode` = 1) writes old value minus the operand. `shiftAmt` is ignored for subtract.
- R4: A load (`opCode` = 2) writes the shifted operand into the selected accumulator, discarding its old value.
- R5: With `srcSel` = 1 the operand is `wordIn` placed in bits 31..16, sign-extended through bit 39, with bits 15..0 zero. With `srcSel` = 0 it is `prodIn` taken as a signed 40-bit value.
- R6: `shiftAmt` is a 5-bit two's-complement value from -16 to +15. A positive value shifts the operand left. A negative value shifts it right arithmetically.
- R7: The overflow flag of the written accumulator is set when the exact result lies outside the signed 40-bit range, and cleared by a write whose exact result fits.
- R8: With `satEn` high, an overflowing result is stored as 0x7FFFFFFFFF if the exact result is positive, or as 0x8000000000 if it is negative. With `satEn` low, the low 40 bits of the exact result are stored.
- R9: The guard flag of an accumulator is high exactly when bits 39..31 of its stored value are not all equal.
- R10: With `opValid` low, or with the reserved `opCode` 3, no accumulator and no flag changes.
- R11: A write to one accumulator leaves the other accumulator and its flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Perform the operation this cycle |
| opCode | input | 2 | 0 add, 1 subtract, 2 load, 3 reserved (no-op) |
| accSel | input | 1 | Target accumulator: 0 = A, 1 = B |
| srcSel | input | 1 | Operand source: 0 = product, 1 = 16-bit word |
| prodIn | input | 40 | Sign-extended product operand |
| wordIn | input | 16 | 16-bit fractional word operand |
| shiftAmt | input | 5 | Signed pre-shift for add and load |
| satEn | input | 1 | Clamp on bit-39 overflow |
| accA | output | 40 | Accumulator A |
| accB | output | 40 | Accumulator B |
| ovfA | output | 1 | Bit-39 overflow flag of A |
| ovfB | output | 1 | Bit-39 overflow flag of B |
| guardA | output | 1 | Guard-bit flag of A |
| guardB | output | 1 | Guard-bit flag of B |

## Verification
Some properties are checked on every cycle by assertions. An idle or reserved cycle holds all state. A write leaves the unselected accumulator and its flags untouched. The guard flags always agree with the stored bits 39..31. A saturating write that overflows leaves one of the two clamp values. The arithmetic values themselves can only be shown by the bench's scenarios: the word alignment, the left and arithmetic right shifts at the +15 and -16 limits, the shift being ignored on subtract, wrap versus clamp on both signs, and overflow caused by a shifted load.

// File: rtl/accu_pkg.sv
package accu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_LOAD = 2'd2,
    OP_NONE = 2'd3
  } accOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrA;
    logic wrB;
    logic doSub;
    logic doLoad;
    logic applyShift;
    logic useWord;
    logic satOn;
  } accCtrl_t;

endpackage

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
(
  input  logic       opValid,
  input  logic [1:0] opCode,
  input  logic       accSel,
  input  logic       srcSel,
  input  logic       satEn,
  output accCtrl_t   ctrl
);

  accOp_e op;
  logic   doWrite;

  assign op = accOp_e'(opCode);

  always_comb begin
    // reserved code behaves as a no-op (R10)
    doWrite         = opValid && (op != OP_NONE);
    ctrl            = '0;
    ctrl.wrA        = doWrite && !accSel;
    ctrl.wrB        = doWrite && accSel;
    ctrl.doSub      = (op == OP_SUB);
    ctrl.doLoad     = (op == OP_LOAD);
    // subtract takes the operand unshifted (R3)
    ctrl.applyShift = (op == OP_ADD) || (op == OP_LOAD);
    ctrl.useWord    = srcSel;
    ctrl.satOn      = satEn;
  end

endmodule

// File: rtl/accu_datapath.sv
module accu_datapath
  import accu_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int WORD_W  = 16,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  accCtrl_t           ctrl,
  input  logic [ACC_W-1:0]   prodIn,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  output logic [ACC_W-1:0]   accA,
  output logic [ACC_W-1:0]   accB,
  output logic               ovfA,
  output logic               ovfB,
  output logic               guardA,
  output logic               guardB
);

  localparam int MAX_LSH  = (1 << (SHIFT_W - 1)) - 1;
  localparam int EXT_W    = ACC_W + MAX_LSH + 2;
  localparam int FRAC_MSB = 2 * WORD_W - 1;
  localparam int SIGN_PAD = ACC_W - 2 * WORD_W;
  localparam int NUM_ACC  = 2;
  localparam logic [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0]        accQ   [NUM_ACC];
  logic [NUM_ACC-1:0]      ovfQ;
  logic [NUM_ACC-1:0]      guardQ;
  logic [NUM_ACC-1:0]      wrVec;

  logic [ACC_W-1:0]        srcVal;
  logic [ACC_W-1:0]        curAcc;
  logic signed [EXT_W-1:0] srcExt;
  logic signed [EXT_W-1:0] accExt;
  logic signed [EXT_W-1:0] shifted;
  logic signed [EXT_W-1:0] rawSum;
  logic [SHIFT_W-1:0]      rightMag;
  logic [EXT_W-ACC_W:0]    topBits;
  logic [ACC_W-FRAC_MSB-1:0] guardBits;
  logic                    ovfNow;
  logic                    guardNow;
  logic [ACC_W-1:0]        result;

  assign wrVec = {ctrl.wrB, ctrl.wrA};

  // operand alignment (R5)
  assign srcVal = ctrl.useWord
                ? {{SIGN_PAD{wordIn[WORD_W-1]}}, wordIn, {WORD_W{1'b0}}}
                : prodIn;
  assign srcExt = {{(EXT_W-ACC_W){srcVal[ACC_W-1]}}, srcVal};

  assign curAcc = ctrl.wrB ? accQ[1] : accQ[0];
  assign accExt = {{(EXT_W-ACC_W){curAcc[ACC_W-1]}}, curAcc};

  // signed pre-shift (R6); magnitude of -16 wraps to 16 as unsigned
  assign rightMag = SHIFT_W'(-shiftAmt);

  always_comb begin
    if (!ctrl.applyShift)
      shifted = srcExt;
    else if (!shiftAmt[SHIFT_W-1])
      shifted = srcExt <<< shiftAmt;
    else
      shifted = srcExt >>> rightMag;
  end

  always_comb begin
    if (ctrl.doLoad)
      rawSum = shifted;
    else if (ctrl.doSub)
      rawSum = accExt - shifted;
    else
      rawSum = accExt + shifted;
  end

  // exact result fits in 40 bits only if bits above 39 copy bit 39 (R7)
  assign topBits = rawSum[EXT_W-1:ACC_W-1];
  assign ovfNow  = !((&topBits) || !(|topBits));

  always_comb begin
    if (ovfNow && ctrl.satOn)
      result = rawSum[EXT_W-1] ? SAT_MIN : SAT_MAX;
    else
      result = rawSum[ACC_W-1:0];
  end

  assign guardBits = result[ACC_W-1:FRAC_MSB];
  assign guardNow  = !((&guardBits) || !(|guardBits));

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ[g]   <= '0;
        ovfQ[g]   <= 1'b0;
        guardQ[g] <= 1'b0;
      end else if (wrVec[g]) begin
        accQ[g]   <= result;
        ovfQ[g]   <= ovfNow;
        guardQ[g] <= guardNow;
      end
    end
  end

  assign accA   = accQ[0];
  assign accB   = accQ[1];
  assign ovfA   = ovfQ[0];
  assign ovfB   = ovfQ[1];
  assign guardA = guardQ[0];
  assign guardB = guardQ[1];

endmodule

// File: rtl/accu_dual40.sv
module accu_dual40
  import accu_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int WORD_W  = 16,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               opValid,
  input  logic [1:0]         opCode,
  input  logic               accSel,
  input  logic               srcSel,
  input  logic [ACC_W-1:0]   prodIn,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic               satEn,
  output logic [ACC_W-1:0]   accA,
  output logic [ACC_W-1:0]   accB,
  output logic               ovfA,
  output logic               ovfB,
  output logic               guardA,
  output logic               guardB
);

  accCtrl_t ctrl;

  accu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .accSel  (accSel),
    .srcSel  (srcSel),
    .satEn   (satEn),
    .ctrl    (ctrl)
  );

  accu_datapath #(
    .ACC_W   (ACC_W),
    .WORD_W  (WORD_W),
    .SHIFT_W (SHIFT_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl),
    .prodIn   (prodIn),
    .wordIn   (wordIn),
    .shiftAmt (shiftAmt),
    .accA     (accA),
    .accB     (accB),
    .ovfA     (ovfA),
    .ovfB     (ovfB),
    .guardA   (guardA),
    .guardB   (guardB)
  );

endmodule

// File: rtl/accu_dual40_chk.sv
module accu_dual40_chk #(
  parameter int ACC_W = 40,
  parameter int WORD_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             opValid,
  input logic [1:0]       opCode,
  input logic             accSel,
  input logic             satEn,
  input logic [ACC_W-1:0] accA,
  input logic [ACC_W-1:0] accB,
  input logic             ovfA,
  input logic             ovfB,
  input logic             guardA,
  input logic             guardB
);

  localparam int FRAC_MSB = 2 * WORD_W - 1;
  localparam logic [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic idleCyc;
  logic mixedA, mixedB;
  assign idleCyc = !opValid || (opCode == 2'd3);
  assign mixedA  = !((&accA[ACC_W-1:FRAC_MSB]) || !(|accA[ACC_W-1:FRAC_MSB]));
  assign mixedB  = !((&accB[ACC_W-1:FRAC_MSB]) || !(|accB[ACC_W-1:FRAC_MSB]));

  // R10: nothing moves on an idle or reserved cycle
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idleCyc |=> ($stable(accA) && $stable(accB) && $stable(ovfA) &&
                 $stable(ovfB) && $stable(guardA) && $stable(guardB)));

  // R11: writing A leaves B untouched
  a_r11_b_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && !accSel) |=> ($stable(accB) && $stable(ovfB) && $stable(guardB)));

  // R11: writing B leaves A untouched
  a_r11_a_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && accSel) |=> ($stable(accA) && $stable(ovfA) && $stable(guardA)));

  // R9: guard flags track the stored top bits
  a_r9_guard_a: assert property (@(posedge clk) disable iff (!rst_n)
    guardA == mixedA);
  a_r9_guard_b: assert property (@(posedge clk) disable iff (!rst_n)
    guardB == mixedB);

  // R8: a saturating write that overflows leaves a clamp value
  a_r8_clamp_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!idleCyc && !accSel && satEn) |=> (!ovfA || accA == SAT_MAX || accA == SAT_MIN));
  a_r8_clamp_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!idleCyc && accSel && satEn) |=> (!ovfB || accB == SAT_MAX || accB == SAT_MIN));

endmodule

bind accu_dual40 accu_dual40_chk #(
  .ACC_W  (ACC_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opValid (opValid),
  .opCode  (opCode),
  .accSel  (accSel),
  .satEn   (satEn),
  .accA    (accA),
  .accB    (accB),
  .ovfA    (ovfA),
  .ovfB    (ovfB),
  .guardA  (guardA),
  .guardB  (guardB)
);

// File: tb/accu_dual40_tb.sv
module accu_dual40_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opCode = 2'd0;
  logic        accSel = 1'b0;
  logic        srcSel = 1'b0;
  logic [39:0] prodIn = '0;
  logic [15:0] wordIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic        satEn = 1'b0;
  logic [39:0] accA, accB;
  logic        ovfA, ovfB, guardA, guardB;

  int nChecks = 0;
  int nErrors = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  accu_dual40 u_dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .accSel(accSel), .srcSel(srcSel), .prodIn(prodIn), .wordIn(wordIn),
    .shiftAmt(shiftAmt), .satEn(satEn), .accA(accA), .accB(accB),
    .ovfA(ovfA), .ovfB(ovfB), .guardA(guardA), .guardB(guardB)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        valid;
    logic [1:0]  op;
    logic        sel;
    logic        src;
    logic [4:0]  shift;
    logic        sat;
    logic [39:0] prod;
    logic [15:0] word;
    logic [39:0] expA;
    logic [39:0] expB;
    logic        eOvA;
    logic        eOvB;
    logic        eGdA;
    logic        eGdB;
  } vec_t;

  // op: 0 add, 1 sub, 2 load, 3 reserved; sel 0=A; src 1=word
  localparam vec_t VECS [16] = '{
    // R4/R5 load word 0x1234 into A
    '{4'd5, 1'b1, 2'd2, 1'b0, 1'b1, 5'd0,  1'b0, 40'h0, 16'h1234, 40'h0012340000, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R2/R6 add product shifted left 4
    '{4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 5'd4,  1'b0, 40'h100, 16'h0, 40'h0012341000, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R3 subtract from B, shift ignored
    '{4'd3, 1'b1, 2'd1, 1'b1, 1'b0, 5'd4,  1'b0, 40'h10, 16'h0, 40'h0012341000, 40'hFFFFFFFFF0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R6 load negative word, arithmetic right 4
    '{4'd6, 1'b1, 2'd2, 1'b1, 1'b1, 5'h1C, 1'b0, 40'h0, 16'h8000, 40'h0012341000, 40'hFFF8000000, 1'b0, 1'b0, 1'b0, 1'b0},
    // R9 add spills into guard bits
    '{4'd9, 1'b1, 2'd0, 1'b0, 1'b1, 5'd1,  1'b0, 40'h0, 16'h4000, 40'h0092341000, 40'hFFF8000000, 1'b0, 1'b0, 1'b1, 1'b0},
    // R4 load max product
    '{4'd4, 1'b1, 2'd2, 1'b0, 1'b0, 5'd0,  1'b1, 40'h7FFFFFFFFF, 16'h0, 40'h7FFFFFFFFF, 40'hFFF8000000, 1'b0, 1'b0, 1'b1, 1'b0},
    // R8 positive overflow clamps
    '{4'd8, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  1'b1, 40'h1, 16'h0, 40'h7FFFFFFFFF, 40'hFFF8000000, 1'b1, 1'b0, 1'b1, 1'b0},
    // R8 positive overflow wraps without saturation
    '{4'd8, 1'b1, 2'd0, 1'b0, 1'b0, 5'd0,  1'b0, 40'h1, 16'h0, 40'h8000000000, 40'hFFF8000000, 1'b1, 1'b0, 1'b1, 1'b0},
    // R7 negative overflow on subtract clamps
    '{4'd7, 1'b1, 2'd1, 1'b0, 1'b0, 5'd0,  1'b1, 40'h1, 16'h0, 40'h8000000000, 40'hFFF8000000, 1'b1, 1'b0, 1'b1, 1'b0},
    // R7 fitting write clears flag; R6 left 15
    '{4'd7, 1'b1, 2'd2, 1'b0, 1'b1, 5'd15, 1'b1, 40'h0, 16'h0001, 40'h0080000000, 40'hFFF8000000, 1'b0, 1'b0, 1'b1, 1'b0},
    // R8 shifted load overflows and clamps
    '{4'd8, 1'b1, 2'd2, 1'b1, 1'b1, 5'd15, 1'b1, 40'h0, 16'h7FFF, 40'h0080000000, 40'h7FFFFFFFFF, 1'b0, 1'b1, 1'b1, 1'b1},
    // R6 right 16 of -1 stays -1
    '{4'd6, 1'b1, 2'd2, 1'b1, 1'b0, 5'h10, 1'b0, 40'hFFFFFFFFFF, 16'h0, 40'h0080000000, 40'hFFFFFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0},
    // R10 reserved op code
    '{4'd10, 1'b1, 2'd3, 1'b0, 1'b0, 5'd0, 1'b1, 40'h5, 16'h5, 40'h0080000000, 40'hFFFFFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0},
    // R10 valid low
    '{4'd10, 1'b0, 2'd0, 1'b0, 1'b0, 5'd0, 1'b0, 40'h5, 16'h0, 40'h0080000000, 40'hFFFFFFFFFF, 1'b0, 1'b0, 1'b1, 1'b0},
    // R6 right 16 of positive product
    '{4'd6, 1'b1, 2'd2, 1'b0, 1'b0, 5'h10, 1'b0, 40'h0000120000, 16'h0, 40'h0000000012, 40'hFFFFFFFFFF, 1'b0, 1'b0, 1'b0, 1'b0},
    // R3/R11 subtract word from B, shift 3 ignored
    '{4'd3, 1'b1, 2'd1, 1'b1, 1'b1, 5'd3,  1'b0, 40'h0, 16'h0002, 40'h0000000012, 40'hFFFFFDFFFF, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk40(input string tag, input string what, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chkAll(input string tag, input logic [39:0] eA, input logic [39:0] eB,
                        input logic oA, input logic oB, input logic gA, input logic gB);
    chk40(tag, "accA", accA, eA);
    chk40(tag, "accB", accB, eB);
    chk40(tag, "ovfA", {39'd0, ovfA}, {39'd0, oA});
    chk40(tag, "ovfB", {39'd0, ovfB}, {39'd0, oB});
    chk40(tag, "guardA", {39'd0, guardA}, {39'd0, gA});
    chk40(tag, "guardB", {39'd0, guardB}, {39'd0, gB});
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic sel, input logic src,
                       input logic [4:0] sh, input logic sat, input logic [39:0] p, input logic [15:0] w);
    opValid = v; opCode = op; accSel = sel; srcSel = src;
    shiftAmt = sh; satEn = sat; prodIn = p; wordIn = w;
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chkAll("R1", 40'h0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      drive(VECS[i].valid, VECS[i].op, VECS[i].sel, VECS[i].src,
            VECS[i].shift, VECS[i].sat, VECS[i].prod, VECS[i].word);
      @(negedge clk);
      chkAll($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].expA, VECS[i].expB,
             VECS[i].eOvA, VECS[i].eOvB, VECS[i].eGdA, VECS[i].eGdB);
    end

    // R8 negative clamp: -2^39 load is exact, then doubling overflows
    drive(1'b1, 2'd2, 1'b1, 1'b1, 5'd8, 1'b1, 40'h0, 16'h8000);
    @(negedge clk);
    chkAll("R4 exact min", 40'h12, 40'h8000000000, 1'b0, 1'b0, 1'b0, 1'b1);
    drive(1'b1, 2'd0, 1'b1, 1'b1, 5'd8, 1'b1, 40'h0, 16'h8000);
    @(negedge clk);
    chkAll("R8 neg clamp", 40'h12, 40'h8000000000, 1'b0, 1'b1, 1'b0, 1'b1);
    drive(1'b1, 2'd0, 1'b1, 1'b1, 5'd8, 1'b0, 40'h0, 16'h8000);
    @(negedge clk);
    chkAll("R8 neg wrap", 40'h12, 40'h0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R11 back-to-back writes alternate targets
    drive(1'b1, 2'd0, 1'b0, 1'b0, 5'd0, 1'b0, 40'h1, 16'h0);
    @(negedge clk);
    drive(1'b1, 2'd1, 1'b1, 1'b0, 5'd0, 1'b0, 40'h3, 16'h0);
    @(negedge clk);
    chkAll("R11 alternate", 40'h13, 40'hFFFFFFFFFD, 1'b0, 1'b0, 1'b0, 1'b0);

    // R1 asynchronous reset mid-run
    drive(1'b0, 2'd0, 1'b0, 1'b0, 5'd0, 1'b0, 40'h0, 16'h0);
    #1 rst_n = 1'b0;
    #0.5;
    chkAll("R1 async", 40'h0, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule